// File: doc/BRIEF.md
# Power Rail Control Pin Driver

This block drives a small set of output pins that switch the supply rails of peripheral devices as the chip moves between its power modes. The current power mode arrives as a one-hot vector. Each pin has its own configuration: a mask that names the modes in which the pin is active, a software-direct select, a software level, and a polarity bit. When the software-direct select is clear, the pin is active in every mode whose mask bit is set. When the select is set, the software level drives the pin and the mode has no effect. The polarity bit decides whether "active" means a high or a low level on the pin.

Software writes the configuration through a simple write port that gives a pin index, a field kind and a data word. A rising edge on the external reset input, delivered as a one-cycle indication, puts every pin except pin 3 into a defined software-driven state. Pin 3 keeps its configuration and so its level. Power-on reset clears all configuration, so every pin is low. All pin outputs are registered. A pin therefore changes only on a clock edge, one cycle after the mode or configuration that causes the change.

Top module: `rail_ctl_pins`

## Requirements
- R1: While power-on reset is asserted and on the first cycle after it, every pin is low, because all masks, selects, software levels and polarity bits are cleared.
- R2: When a pin's software select is 0, the pin is active exactly when the AND of its mask and `mode_i` is nonzero. The pin shows this on the clock edge after the mode is sampled. Mode bits: 0 high-speed, 1 low-speed, 2 doze, 3 sleep, 4 suspend, 5 off.
- R3: A mask may hold any combination of mode bits. The pin is active in each mode whose bit is set and inactive in every other mode.
- R4: When a pin's software select is 1, the pin's active state equals its software level, whatever the mode.
- R5: The output level is the active state XOR the pin's polarity bit. Polarity 1 makes the pin active-low.
- R6: On a cycle with `resin_rise_i` high, pins 0, 1, 2 and 4 take `RESIN_LEVEL` (default 5'b00001) at the next edge. They then hold that level in every mode until software rewrites them: mask cleared, select 1, software level from `RESIN_LEVEL`, polarity 0.
- R7: Pin 3 ignores `resin_rise_i`. Its configuration, and so its level, is unchanged by the reset-input edge.
- R8: If a write to pin 0, 1, 2 or 4 falls in the same cycle as `resin_rise_i`, the reset-input defaults win. A write to pin 3 in that cycle takes effect.
- R9: Write field kinds for `wr_kind_i`: 0 sets the mask from `wr_data_i[5:0]`, 1 sets the software level from bit 0, 2 sets the software select from bit 0, and 3 sets the polarity from bit 0. A write whose pin index is 5 or more changes no pin.
- R10: A write to one pin leaves the configuration and level of every other pin unchanged.
- R11: With the mode unchanged and no write or reset-input edge for two cycles, no pin changes level. Pins never move between clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| mode_i | input | 6 | One-hot current power mode |
| resin_rise_i | input | 1 | One-cycle indication of a rising edge on the external reset input |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_kind_i | input | 2 | Field selected by the write (mask, level, select, polarity) |
| wr_pin_i | input | 3 | Index of the pin being written |
| wr_data_i | input | 6 | Write data; the full width for masks, bit 0 for the other fields |
| pin_o | output | 5 | Registered rail control pin levels |

## Verification
The bench keeps a model of every pin's configuration. It goes after the reset-input edge while pin 3 is software-driven high. A design that also forced pin 3, or that failed to make the forced defaults stick across later mode changes, would show wrong levels there. It sends writes that collide with the reset-input edge, to pin 3 and to a forced pin. This catches a priority that is swapped or applied to the wrong pin. It also sends writes to pin indices 5 to 7, which an index decode that aliases would route into a real pin. Multi-mode masks swept through every mode, combined with inverted polarity, catch a single-mode compare or a missing inversion. Random traffic mixes all of these.

// File: rtl/rail_ctl_pkg.sv
package rail_ctl_pkg;

    // Number of power modes carried by the one-hot mode vector.
    localparam int PM_MODES = 6;

    // Mode bit positions inside mode_i.
    localparam int MODE_HI_SPEED  = 0;
    localparam int MODE_LO_SPEED  = 1;
    localparam int MODE_DOZE      = 2;
    localparam int MODE_SLEEP     = 3;
    localparam int MODE_SUSPEND   = 4;
    localparam int MODE_OFF       = 5;

    // Field selected by a configuration write (R9).
    typedef enum logic [1:0] {
        KIND_MASK  = 2'd0,
        KIND_SWVAL = 2'd1,
        KIND_SWSEL = 2'd2,
        KIND_POL   = 2'd3
    } wr_kind_e;

    // Per-pin configuration.
    typedef struct packed {
        logic [PM_MODES-1:0] mask;
        logic                swval;
        logic                swsel;
        logic                pol;
    } pin_cfg_t;

endpackage

// File: rtl/rail_pin_eval.sv
module rail_pin_eval
    import rail_ctl_pkg::*;
(
    input  pin_cfg_t            cfg_i,
    input  logic [PM_MODES-1:0] mode_i,
    output logic                level_o
);

    logic mode_hit;
    logic active;

    always_comb begin
        // R2/R3: active in any mode whose mask bit is set
        mode_hit = |(cfg_i.mask & mode_i);
        // R4: the software-direct select overrides the mode
        active   = cfg_i.swsel ? cfg_i.swval : mode_hit;
        // R5: polarity selects an active-high or active-low pin
        level_o  = active ^ cfg_i.pol;
    end

endmodule

// File: rtl/rail_cfg_slot.sv
module rail_cfg_slot
    import rail_ctl_pkg::*;
#(
    parameter bit FORCE_ON_RESIN = 1'b1,
    parameter bit RESIN_BIT      = 1'b0
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                resin_rise_i,
    input  logic                wr_hit_i,
    input  wr_kind_e            wr_kind_i,
    input  logic [PM_MODES-1:0] wr_data_i,
    output pin_cfg_t            cfg_o
);

    pin_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (FORCE_ON_RESIN && resin_rise_i) begin
            // R6/R8: reset-input defaults beat a same-cycle write
            cfg_d.mask  = '0;
            cfg_d.swval = RESIN_BIT;
            cfg_d.swsel = 1'b1;
            cfg_d.pol   = 1'b0;
        end else if (wr_hit_i) begin
            unique case (wr_kind_i)
                KIND_MASK:  cfg_d.mask  = wr_data_i;
                KIND_SWVAL: cfg_d.swval = wr_data_i[0];
                KIND_SWSEL: cfg_d.swsel = wr_data_i[0];
                KIND_POL:   cfg_d.pol   = wr_data_i[0];
                default:    cfg_d       = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;     // R1
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/rail_ctl_pins.sv
module rail_ctl_pins
    import rail_ctl_pkg::*;
#(
    parameter int                  NUM_PINS    = 5,
    parameter logic [NUM_PINS-1:0] RESIN_LEVEL = 5'b00001,
    parameter logic [NUM_PINS-1:0] RESIN_KEEP  = 5'b01000,
    localparam int                 PIN_IDX_W   = $clog2(NUM_PINS)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [PM_MODES-1:0]  mode_i,
    input  logic                 resin_rise_i,
    input  logic                 wr_en_i,
    input  logic [1:0]           wr_kind_i,
    input  logic [PIN_IDX_W-1:0] wr_pin_i,
    input  logic [PM_MODES-1:0]  wr_data_i,
    output logic [NUM_PINS-1:0]  pin_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] pins;
    } pin_state_t;

    pin_state_t st_d, st_q;

    wr_kind_e            kind;
    pin_cfg_t            cfg   [NUM_PINS];
    logic [NUM_PINS-1:0] level;
    logic [NUM_PINS-1:0] wr_hit;

    assign kind = wr_kind_e'(wr_kind_i);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        // R9/R10: only the addressed, existing pin is written
        assign wr_hit[i] = wr_en_i && (wr_pin_i == PIN_IDX_W'(i));

        rail_cfg_slot #(
            .FORCE_ON_RESIN (!RESIN_KEEP[i]),   // R7: kept pins ignore the edge
            .RESIN_BIT      (RESIN_LEVEL[i])
        ) u_slot (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .resin_rise_i (resin_rise_i),
            .wr_hit_i     (wr_hit[i]),
            .wr_kind_i    (kind),
            .wr_data_i    (wr_data_i),
            .cfg_o        (cfg[i])
        );

        rail_pin_eval u_eval (
            .cfg_i   (cfg[i]),
            .mode_i  (mode_i),
            .level_o (level[i])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (resin_rise_i && !RESIN_KEEP[i]) begin
                st_d.pins[i] = RESIN_LEVEL[i];   // R6
            end else begin
                st_d.pins[i] = level[i];         // R2..R5, R11
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;      // R1
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_o = st_q.pins;

endmodule

// File: rtl/rail_ctl_pins_chk.sv
module rail_ctl_pins_chk #(
    parameter int                  NUM_PINS    = 5,
    parameter logic [NUM_PINS-1:0] RESIN_LEVEL = 5'b00001,
    parameter logic [NUM_PINS-1:0] RESIN_KEEP  = 5'b01000,
    parameter int                  PIN_IDX_W   = 3,
    parameter int                  MODES       = 6
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [MODES-1:0]     mode_i,
    input logic                 resin_rise_i,
    input logic                 wr_en_i,
    input logic [PIN_IDX_W-1:0] wr_pin_i,
    input logic [NUM_PINS-1:0]  pin_o
);

    localparam logic [NUM_PINS-1:0] FORCED = ~RESIN_KEEP;

    AST_POR_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (pin_o == '0)) else $error("AST_POR_LOW"); // R1

    AST_RESIN_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resin_rise_i |=> ((pin_o & FORCED) == (RESIN_LEVEL & FORCED)))
        else $error("AST_RESIN_LEVEL"); // R6

    AST_RESIN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(resin_rise_i) && !$past(wr_en_i) && !wr_en_i && !resin_rise_i)
        |=> $stable(pin_o & FORCED)) else $error("AST_RESIN_STICKY"); // R6

    AST_QUIET_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($stable(mode_i) && !wr_en_i && !resin_rise_i &&
         !$past(wr_en_i) && !$past(resin_rise_i))
        |=> $stable(pin_o)) else $error("AST_QUIET_STABLE"); // R11

    AST_BAD_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($stable(mode_i) && wr_en_i && (int'(wr_pin_i) >= NUM_PINS) &&
         !resin_rise_i && !$past(wr_en_i) && !$past(resin_rise_i))
        |=> $stable(pin_o)) else $error("AST_BAD_INDEX"); // R9

endmodule

bind rail_ctl_pins rail_ctl_pins_chk #(
    .NUM_PINS    (NUM_PINS),
    .RESIN_LEVEL (RESIN_LEVEL),
    .RESIN_KEEP  (RESIN_KEEP),
    .PIN_IDX_W   (PIN_IDX_W),
    .MODES       (rail_ctl_pkg::PM_MODES)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode_i),
    .resin_rise_i (resin_rise_i),
    .wr_en_i      (wr_en_i),
    .wr_pin_i     (wr_pin_i),
    .pin_o        (pin_o)
);

// File: tb/sim_rail_ctl_pins.sv
`timescale 1ns/1ps
module sim_rail_ctl_pins;

    localparam int       NP = 5;
    localparam int       NM = 6;
    localparam logic [4:0] RL = 5'b00001;
    localparam int       KEEP_PIN = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NM-1:0] mode = 6'b000001;
    logic          resin = 1'b0;
    logic          we = 1'b0;
    logic [1:0]    kind = 2'd0;
    logic [2:0]    wpin = 3'd0;
    logic [NM-1:0] wdata = '0;
    logic [NP-1:0] pins;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model of the configuration
    logic [NM-1:0] m_mask [NP];
    logic          m_sw   [NP];
    logic          m_sel  [NP];
    logic          m_pol  [NP];

    always #2 clk = ~clk;   // 250 MHz

    rail_ctl_pins u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .mode_i       (mode),
        .resin_rise_i (resin),
        .wr_en_i      (we),
        .wr_kind_i    (kind),
        .wr_pin_i     (wpin),
        .wr_data_i    (wdata),
        .pin_o        (pins)
    );

    function automatic logic exp_level(int i, logic [NM-1:0] md);
        logic act;
        act = m_sel[i] ? m_sw[i] : |(m_mask[i] & md);
        return act ^ m_pol[i];
    endfunction

    task automatic check(string req, logic [NP-1:0] act, logic [NP-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pins=%b expected=%b", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs, update the model, compare after the edge.
    task automatic step(string req, logic [NM-1:0] md, logic rs, logic w,
                        logic [1:0] k, logic [2:0] p, logic [NM-1:0] d);
        logic [NP-1:0] exp;
        mode = md; resin = rs; we = w; kind = k; wpin = p; wdata = d;
        for (int i = 0; i < NP; i++)
            exp[i] = (rs && i != KEEP_PIN) ? RL[i] : exp_level(i, md);
        for (int i = 0; i < NP; i++) begin
            if (rs && i != KEEP_PIN) begin
                m_mask[i] = '0; m_sw[i] = RL[i]; m_sel[i] = 1'b1; m_pol[i] = 1'b0;
            end else if (w && int'(p) == i) begin
                case (k)
                    2'd0: m_mask[i] = d;
                    2'd1: m_sw[i]   = d[0];
                    2'd2: m_sel[i]  = d[0];
                    default: m_pol[i] = d[0];
                endcase
            end
        end
        @(posedge clk); #1;
        check(req, pins, exp);
    endtask

    task automatic wr(logic [2:0] p, logic [1:0] k, logic [NM-1:0] d);
        step("R9", mode, 1'b0, 1'b1, k, p, d);
    endtask

    task automatic idle(string req, logic [NM-1:0] md);
        step(req, md, 1'b0, 1'b0, 2'd0, 3'd0, '0);
    endtask

    initial begin
        #400_000;
        n_fail++;
        $display("FAIL watchdog: pins=%b expected=finished run", pins);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [NP-1:0] snap;
        void'($urandom(32'd2024));
        for (int i = 0; i < NP; i++) begin
            m_mask[i] = '0; m_sw[i] = 0; m_sel[i] = 0; m_pol[i] = 0;
        end
        #1;
        check("R1 in reset", pins, '0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1 after reset", pins, '0);
        idle("R1", 6'b100000);

        // typical mapping: pin0 fast modes, pin1 doze, pin2 sleep, pins3/4 suspend
        wr(3'd0, 2'd0, 6'b000011);
        wr(3'd1, 2'd0, 6'b000100);
        wr(3'd2, 2'd0, 6'b001000);
        wr(3'd3, 2'd0, 6'b010000);
        wr(3'd4, 2'd0, 6'b010000);
        for (int m = 0; m < NM; m++) idle("R2 mode walk", 6'(1 << m));

        // combination mask on pin 1 swept through all modes
        wr(3'd1, 2'd0, 6'b100101);
        for (int m = 0; m < NM; m++) idle("R3 combo", 6'(1 << m));

        // polarity
        wr(3'd2, 2'd3, 6'b000001);
        for (int m = 0; m < NM; m++) idle("R5 polarity", 6'(1 << m));

        // software direct on pin 4, mode ignored
        wr(3'd4, 2'd2, 6'b000001);
        wr(3'd4, 2'd1, 6'b000001);
        for (int m = 0; m < NM; m++) idle("R4 sw direct", 6'(1 << m));

        // independence: rewriting pin 0 leaves others
        idle("R10", 6'b000100);
        snap = pins;
        step("R10 write pin0", 6'b000100, 1'b0, 1'b1, 2'd0, 3'd0, 6'b000100);
        idle("R10", 6'b000100);
        check("R10 others unchanged", pins & 5'b11110, snap & 5'b11110);

        // bad index writes
        for (int p = 5; p < 8; p++) begin
            snap = pins;
            step("R9 bad index", 6'b000100, 1'b0, 1'b1, 2'd0, 3'(p), 6'b111111);
            idle("R9", 6'b000100);
            check("R9 bad index no change", pins, snap);
        end

        // quiet hold
        snap = pins;
        repeat (4) idle("R11", 6'b000100);
        check("R11 quiet hold", pins, snap);

        // reset-input edge with pin 3 software high
        wr(3'd3, 2'd2, 6'b000001);
        wr(3'd3, 2'd1, 6'b000001);
        step("R6 R7 resin", 6'b000001, 1'b1, 1'b0, 2'd0, 3'd0, '0);
        check("R7 pin3 kept", {4'b0, pins[3]}, 5'b00001);
        for (int m = 0; m < NM; m++) idle("R6 sticky", 6'(1 << m));

        // collisions with the reset-input edge
        wr(3'd0, 2'd2, 6'b000000);
        step("R8 resin beats pin0 write", 6'b000010, 1'b1, 1'b1, 2'd1, 3'd0, 6'b000000);
        idle("R8", 6'b000010);
        step("R8 pin3 write lands", 6'b000010, 1'b1, 1'b1, 2'd3, 3'd3, 6'b000001);
        idle("R8", 6'b000010);
        check("R8 pin3 inverted", {4'b0, pins[3]}, 5'b00000);

        // random traffic
        for (int n = 0; n < 400; n++) begin
            logic [NM-1:0] md;
            md = 6'(1 << ($urandom % NM));
            step("R2 R4 random", md, ($urandom % 20) == 0, ($urandom % 3) == 0,
                 2'($urandom), 3'($urandom), 6'($urandom));
        end
        idle("R11", 6'b000001);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule